// File: doc/BRIEF.md
# Programmable Pin Input Debouncer

This block cleans up one general-purpose input pin before the level reaches input status and interrupt detection. The raw pad level is brought into the system clock domain by a two-flop synchronizer and then filtered according to a per-pin configuration. The configuration has a 2-bit filter mode, two unit-select bits and a 4-bit unit count. Time is measured in units of a slow real-time clock. That clock arrives as a single-cycle enable pulse (`rtc_tick`) in the system clock domain, and a prescaler divides it into units.

A small state machine does the filtering. Its states are BYPASS (the filter is off and the output follows the synchronized level), STEADY (the output matches the input, or a pass-through edge is applied) and QUALIFY (a new level is being timed). The transitions are: mode-off, which goes to BYPASS from any state. Mode-on goes from BYPASS to STEADY. Level-differs goes from STEADY to QUALIFY when the edge must be debounced. Revert goes from QUALIFY to STEADY when the input returns to the output level, and the timed level is dropped. Pass goes from QUALIFY to STEADY when the mode now lets the edge straight through. Accept goes from QUALIFY to STEADY when the last unit ends, and the output takes the new level.

Top module: `pin_debounce`

## Requirements
- R1: While reset is asserted and right after it is released, `pin_filt` is 0.
- R2: With `cfg_mode` = 0 (filter off), `pin_filt` takes the value of `pin_raw` exactly 3 clock cycles after `pin_raw` changes: two synchronizer stages plus the output register.
- R3: The unit-select pair {`cfg_unit_large`, `cfg_unit_out`} sets the length of one unit in `rtc_tick` pulses: {0,0}=2, {0,1}=8, {1,0}=512, {1,1}=2048.
- R4: With `cfg_mode` = 3 (remove-glitch), a new level on both rising and falling edges reaches `pin_filt` only when the rtc_tick pulse that completes `cfg_count` units arrives while the synchronized input has held that level. One tick fewer leaves the output unchanged.
- R5: A `cfg_count` of 0 is timed as one unit.
- R6: If the synchronized input returns to the output level before the timing completes, the partial count is discarded, and a later attempt must time the full period again.
- R7: With `cfg_mode` = 1 (keep-low), a high-to-low change passes in 3 cycles as in R2, and a low-to-high change is timed as in R4.
- R8: With `cfg_mode` = 2 (keep-high), a low-to-high change passes in 3 cycles, and a high-to-low change is timed as in R4.
- R9: Any change of `cfg_mode`, the unit-select bits or `cfg_count` during timing restarts both the prescaler and the unit count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle enable pulse per real-time clock period |
| pin_raw | input | 1 | Unsynchronized pad level |
| cfg_mode | input | 2 | 0 off, 1 keep-low, 2 keep-high, 3 remove-glitch |
| cfg_unit_large | input | 1 | Upper unit-select bit |
| cfg_unit_out | input | 1 | Lower unit-select bit |
| cfg_count | input | 4 | Number of units to time (0 means 1) |
| pin_filt | output | 1 | Filtered pin level |

## Verification
A pass-through result is due on the third rising edge after `pin_raw` is driven. The bench samples on the falling edge after the second rising edge, where the old level is expected, and again after the third, where the new level is expected. A timed result is due on the rising edge that samples the completing `rtc_tick`. The bench drives every tick itself after the state machine has reached QUALIFY. It checks the output after one tick short of the expected total and again after the final tick, so the count is checked to the exact tick rather than to a cycle window.

// File: rtl/db_pkg.sv
package db_pkg;

    typedef enum logic [1:0] {
        DB_OFF       = 2'd0,
        DB_KEEP_LOW  = 2'd1,
        DB_KEEP_HIGH = 2'd2,
        DB_FILTER    = 2'd3
    } db_mode_e;

    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_STEADY  = 2'd1,
        ST_QUALIFY = 2'd2
    } db_state_e;

endpackage

// File: rtl/db_sync.sv
module db_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/db_prescale.sv
module db_prescale #(
    parameter int UNIT_P0 = 2,
    parameter int UNIT_P1 = 8,
    parameter int UNIT_P2 = 512,
    parameter int UNIT_P3 = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       rtc_tick,
    input  logic [1:0] sel,
    output logic       unit_tick
);
    localparam int CW = $clog2(UNIT_P3);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (sel)
            2'b00:   lim = CW'(UNIT_P0 - 1);
            2'b01:   lim = CW'(UNIT_P1 - 1);
            2'b10:   lim = CW'(UNIT_P2 - 1);
            default: lim = CW'(UNIT_P3 - 1);
        endcase
    end

    assign unit_tick = rtc_tick && !clr && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clr)       cnt_q <= '0;
        else if (rtc_tick)  cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/db_fsm.sv
module db_fsm
    import db_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl,
    input  logic             unit_tick,
    input  logic [1:0]       mode,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] count,
    output logic             tmr_clr,
    output logic             filt
);
    localparam int CFG_W = 4 + CNT_W;

    db_state_e        state_q, state_d;
    logic             filt_d;
    logic [CNT_W-1:0] units_q;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic [CNT_W-1:0] tgt_m1;
    logic             rising;
    logic             pass;
    logic             done;
    db_mode_e         md;

    assign md      = db_mode_e'(mode);
    assign cfg_chg = (cfg_q != {mode, unit_sel, count});
    assign tmr_clr = (state_q != ST_QUALIFY) || cfg_chg;
    assign tgt_m1  = (count == '0) ? '0 : count - 1'b1;
    assign rising  = sync_lvl && !filt;
    assign pass    = (md == DB_KEEP_LOW && !rising) || (md == DB_KEEP_HIGH && rising);
    assign done    = unit_tick && (units_q == tgt_m1);

    // next state and next output level
    always_comb begin
        state_d = state_q;
        filt_d  = filt;
        unique case (state_q)
            ST_BYPASS: begin
                filt_d = sync_lvl;
                if (md != DB_OFF) state_d = ST_STEADY;
            end
            ST_STEADY: begin
                if (md == DB_OFF) begin
                    state_d = ST_BYPASS;
                    filt_d  = sync_lvl;
                end else if (sync_lvl != filt) begin
                    if (pass) filt_d  = sync_lvl;
                    else      state_d = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (md == DB_OFF) begin
                    state_d = ST_BYPASS;
                    filt_d  = sync_lvl;
                end else if (sync_lvl == filt) begin
                    state_d = ST_STEADY;
                end else if (pass || done) begin
                    state_d = ST_STEADY;
                    filt_d  = sync_lvl;
                end
            end
            default: state_d = ST_STEADY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STEADY;
        else        state_q <= state_d;
    end

    // output and counting registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            units_q <= '0;
            cfg_q   <= '0;
        end else begin
            filt  <= filt_d;
            cfg_q <= {mode, unit_sel, count};
            if (tmr_clr)        units_q <= '0;
            else if (unit_tick) units_q <= units_q + 1'b1;
        end
    end
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int UNIT_P0     = 2,
    parameter int UNIT_P1     = 8,
    parameter int UNIT_P2     = 512,
    parameter int UNIT_P3     = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             pin_raw,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_unit_large,
    input  logic             cfg_unit_out,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             pin_filt
);
    logic sync_lvl;
    logic unit_tick;
    logic tmr_clr;

    db_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .q_out (sync_lvl)
    );

    db_prescale #(
        .UNIT_P0(UNIT_P0), .UNIT_P1(UNIT_P1),
        .UNIT_P2(UNIT_P2), .UNIT_P3(UNIT_P3)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmr_clr),
        .rtc_tick  (rtc_tick),
        .sel       ({cfg_unit_large, cfg_unit_out}),
        .unit_tick (unit_tick)
    );

    db_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_lvl  (sync_lvl),
        .unit_tick (unit_tick),
        .mode      (cfg_mode),
        .unit_sel  ({cfg_unit_large, cfg_unit_out}),
        .count     (cfg_count),
        .tmr_clr   (tmr_clr),
        .filt      (pin_filt)
    );
endmodule

// File: rtl/db_checker.sv
module db_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       sync_lvl,
    input logic       unit_tick,
    input logic       pin_filt
);
    // R2: filter off, output follows synchronized level one cycle later
    a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |=> (pin_filt == $past(sync_lvl)));

    // R4: a remove-glitch change needs a completed unit in the prior cycle
    a_r4_change_needs_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_mode) == 2'd3) && (pin_filt != $past(pin_filt))) |-> $past(unit_tick));

    // R4: output only ever moves toward the synchronized level
    a_r4_toward_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> (pin_filt == $past(sync_lvl)));

    // R7: keep-low passes falling edges at once
    a_r7_fall_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_mode) == 2'd1) && $past(pin_filt) && !$past(sync_lvl)) |-> !pin_filt);

    // R8: keep-high passes rising edges at once
    a_r8_rise_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_mode) == 2'd2) && !$past(pin_filt) && $past(sync_lvl)) |-> pin_filt);

    // R1: output low during reset
    always_ff @(posedge clk) begin
        if (!rst_n) a_r1_reset_low: assert (!pin_filt);
    end
endmodule

bind pin_debounce db_checker u_db_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .sync_lvl  (sync_lvl),
    .unit_tick (unit_tick),
    .pin_filt  (pin_filt)
);

// File: tb/pin_debounce_bench.sv
module pin_debounce_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       pin_raw = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_unit_large = 1'b0;
    logic       cfg_unit_out = 1'b0;
    logic [3:0] cfg_count = 4'd0;
    logic       pin_filt;

    int n_checks = 0;
    int n_fails  = 0;
    logic exp_lvl = 1'b0;

    always #4 clk = ~clk;

    pin_debounce u_pin_debounce (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pin_raw(pin_raw),
        .cfg_mode(cfg_mode), .cfg_unit_large(cfg_unit_large),
        .cfg_unit_out(cfg_unit_out), .cfg_count(cfg_count), .pin_filt(pin_filt)
    );

    function automatic int unit_len(input logic lg, input logic ou);
        case ({lg, ou})
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic int exp_ticks(input logic lg, input logic ou, input logic [3:0] c);
        return unit_len(lg, ou) * ((c == 4'd0) ? 1 : int'(c));
    endfunction

    function automatic bit is_timed(input logic [1:0] m, input logic rise);
        if (m == 2'd3) return 1'b1;
        if (m == 2'd1) return rise;
        if (m == 2'd2) return !rise;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: pin_filt=%0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic lg, input logic ou, input logic [3:0] c);
        @(negedge clk);
        cfg_mode = m; cfg_unit_large = lg; cfg_unit_out = ou; cfg_count = c;
        repeat (3) @(negedge clk);
    endtask

    // drive a new level and check it arrives when due
    task automatic edge_to(input string req, input logic lvl);
        int k;
        @(negedge clk) pin_raw = lvl;
        if (!is_timed(cfg_mode, lvl)) begin
            @(posedge clk); @(posedge clk);
            @(negedge clk) chk(req, pin_filt, exp_lvl);
            @(posedge clk);
            @(negedge clk) chk(req, pin_filt, lvl);
        end else begin
            k = exp_ticks(cfg_unit_large, cfg_unit_out, cfg_count);
            repeat (5) @(negedge clk);
            tick_n(k - 1);
            repeat (2) @(negedge clk);
            chk(req, pin_filt, exp_lvl);
            tick_n(1);
            repeat (2) @(negedge clk);
            chk(req, pin_filt, lvl);
        end
        exp_lvl = lvl;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0d1b));
        repeat (3) @(negedge clk);
        chk("R1", pin_filt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk) chk("R1", pin_filt, 1'b0);

        // R2 filter off
        set_cfg(2'd0, 1'b0, 1'b0, 4'd3);
        edge_to("R2", 1'b1);
        edge_to("R2", 1'b0);

        // R3 each unit size, remove-glitch mode (R4)
        set_cfg(2'd3, 1'b0, 1'b0, 4'd4);
        edge_to("R3_u2", 1'b1);
        set_cfg(2'd3, 1'b0, 1'b1, 4'd3);
        edge_to("R3_u8", 1'b0);
        set_cfg(2'd3, 1'b1, 1'b0, 4'd1);
        edge_to("R3_u512", 1'b1);
        set_cfg(2'd3, 1'b1, 1'b1, 4'd15);
        edge_to("R3_u2048", 1'b0);

        // R5 zero count is one unit
        set_cfg(2'd3, 1'b0, 1'b1, 4'd0);
        edge_to("R5", 1'b1);
        edge_to("R5", 1'b0);

        // R6 reversion restarts timing
        set_cfg(2'd3, 1'b0, 1'b0, 4'd3);
        @(negedge clk) pin_raw = 1'b1;
        repeat (5) @(negedge clk);
        tick_n(5);
        repeat (2) @(negedge clk) chk("R6", pin_filt, 1'b0);
        pin_raw = 1'b0;
        repeat (5) @(negedge clk);
        pin_raw = 1'b1;
        repeat (5) @(negedge clk);
        tick_n(5);
        repeat (2) @(negedge clk);
        chk("R6", pin_filt, 1'b0);
        tick_n(1);
        repeat (2) @(negedge clk);
        chk("R6", pin_filt, 1'b1);
        exp_lvl = 1'b1;

        // R9 config change restarts timing
        set_cfg(2'd3, 1'b0, 1'b0, 4'd2);
        @(negedge clk) pin_raw = 1'b0;
        repeat (5) @(negedge clk);
        tick_n(3);
        @(negedge clk) cfg_count = 4'd5;
        repeat (2) @(negedge clk);
        cfg_count = 4'd2;
        repeat (3) @(negedge clk);
        tick_n(3);
        repeat (2) @(negedge clk);
        chk("R9", pin_filt, 1'b1);
        tick_n(1);
        repeat (2) @(negedge clk);
        chk("R9", pin_filt, 1'b0);
        exp_lvl = 1'b0;

        // R7 keep-low and R8 keep-high
        set_cfg(2'd1, 1'b0, 1'b0, 4'd2);
        edge_to("R7_rise_timed", 1'b1);
        edge_to("R7_fall_pass", 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 4'd1);
        edge_to("R8_rise_pass", 1'b1);
        edge_to("R8_fall_timed", 1'b0);

        // random trials across modes, small units
        for (int t = 0; t < 24; t++) begin
            logic [1:0] m;
            logic       ou;
            logic [3:0] c;
            m  = 2'(1 + ($urandom % 3));
            ou = 1'($urandom % 2);
            c  = 4'($urandom % 16);
            set_cfg(m, 1'b0, ou, c);
            if (m == 2'd1)      edge_to("R7_rand", !exp_lvl);
            else if (m == 2'd2) edge_to("R8_rand", !exp_lvl);
            else                edge_to("R4_rand", !exp_lvl);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule